// File: doc/BRIEF.md
# Multi-Mode Staged Word Shifter

A purely combinational unit that moves the bits of an N-bit word (8 bits by default) by a count from 0 to N-1. A direction input selects left or right. A mode input selects one of three kinds of shift:

- **Logical:** vacated positions are filled with zeros.
- **Arithmetic:** a right shift repeats the sign bit.
- **Circular:** bits that leave one end re-enter at the other.

The structure is a chain of log2(N) stages. Stage k moves the word by 2^k places when bit k of the count is set, and otherwise passes it on unchanged. A shift of 13 places on a wider word is therefore formed from moves of 1, 4 and 8.

The count has exactly log2(N) bits, so a count can never reach N. A rotation is therefore always taken modulo the word width.

The encodings are:

| Input | Code | Meaning |
|---|---|---|
| Mode | 2'b00 | Logical |
| Mode | 2'b01 | Arithmetic |
| Mode | 2'b10 | Circular |
| Mode | 2'b11 | Spare: data passes through |
| Direction | 0 | Left |
| Direction | 1 | Right |

Top module: `log_shifter`

## Requirements
- R1: With mode 2'b00 and direction 0, the output is the input moved left by the count, and the low count bits are 0.
- R2: With mode 2'b00 and direction 1, the output is the input moved right by the count, and the high count bits are 0.
- R3: With mode 2'b01 and direction 1, every vacated high bit takes the input's bit N-1. For example, 1001_0110 shifted by one gives 1100_1011.
- R4: With mode 2'b10 and direction 0, the output is the input rotated left by the count, and no bit is lost. For example, 1001_0110 rotated by one gives 0010_1101.
- R5: With mode 2'b10 and direction 1, the output is the input rotated right by the count, and no bit is lost.
- R6: With mode 2'b01 and direction 0, the output equals the logical left shift of the same input and count.
- R7: A count of 0 returns the input unchanged in every mode and direction.
- R8: Mode 2'b11 returns the input unchanged for every count and direction.
- R9: For every mode, direction and count k, the output equals k successive one-place shifts of the same kind.
- R10: A logical shift by the largest count, N-1, leaves at most one input bit in the output, at the far end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | WIDTH | Word to be shifted |
| amt_i | input | $clog2(WIDTH) | Shift count; bit k enables stage k |
| dir_i | input | 1 | Direction: 0 left, 1 right |
| mode_i | input | 2 | Mode: 00 logical, 01 arithmetic, 10 circular, 11 pass through |
| data_o | output | WIDTH | Shifted word |

## Verification
Properties are checked on every input change:

- zero fill at the vacated end of logical shifts and of an arithmetic left request;
- sign retention at the top of arithmetic right shifts;
- conservation of the number of ones under rotation;
- identity for a zero count and for the spare mode.

Only the bench scenarios can show that the full result of each stage combination equals the repeated single-place model (R9). This applies to the exact bit placement of each shift, the worked examples, and the largest-count boundary.

// File: rtl/log_shifter.sv
module log_shifter #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [CW-1:0]    amt_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] data_o
);
  localparam logic [1:0] M_LOG  = 2'b00;
  localparam logic [1:0] M_ARI  = 2'b01;
  localparam logic [1:0] M_ROT  = 2'b10;

  logic [WIDTH-1:0] stage [CW+1];

  assign stage[0] = data_i;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [WIDTH-1:0] cur, shl, shr, rol, ror, sra, pick;

    assign cur = stage[k];
    assign shl = cur << S;
    assign shr = cur >> S;
    assign rol = shl | (cur >> (WIDTH - S));
    assign ror = shr | (cur << (WIDTH - S));
    assign sra = $signed(cur) >>> S;

    always_comb begin
      case (mode_i)
        M_LOG, M_ARI: pick = dir_i ? ((mode_i == M_ARI) ? sra : shr) : shl;
        M_ROT:        pick = dir_i ? ror : rol;
        default:      pick = cur;
      endcase
    end

    assign stage[k+1] = amt_i[k] ? pick : cur;
  end

  assign data_o = stage[CW];
endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] data_i,
  input logic [CW-1:0]    amt_i,
  input logic             dir_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] data_o
);
  always_comb begin
    if (mode_i == 2'b00 && !dir_i && amt_i != '0)
      AST_LOG_LEFT_FILL: assert (data_o[0] == 1'b0) else $error("zero fill left");   // R1
    if (mode_i == 2'b00 && dir_i && amt_i != '0)
      AST_LOG_RIGHT_FILL: assert (data_o[WIDTH-1] == 1'b0) else $error("zero fill right"); // R2
    if (mode_i == 2'b01 && dir_i)
      AST_SIGN_KEPT: assert (data_o[WIDTH-1] == data_i[WIDTH-1]) else $error("sign"); // R3
    if (mode_i == 2'b10 && !dir_i)
      AST_ROL_ONES: assert ($countones(data_o) == $countones(data_i)) else $error("rol"); // R4
    if (mode_i == 2'b10 && dir_i)
      AST_ROR_ONES: assert ($countones(data_o) == $countones(data_i)) else $error("ror"); // R5
    if (mode_i == 2'b01 && !dir_i && amt_i != '0)
      AST_ARI_LEFT_FILL: assert (data_o[0] == 1'b0) else $error("arith left"); // R6
    if (amt_i == '0)
      AST_ZERO_COUNT: assert (data_o == data_i) else $error("zero count"); // R7
    if (mode_i == 2'b11)
      AST_SPARE_PASS: assert (data_o == data_i) else $error("spare mode"); // R8
  end
endmodule

bind log_shifter log_shifter_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_log_shifter.sv
module test_log_shifter;
  localparam int W = 8;
  localparam int C = $clog2(W);

  logic clk = 1'b0;
  logic [W-1:0] din;
  logic [C-1:0] amt;
  logic         dir;
  logic [1:0]   mode;
  logic [W-1:0] dout;
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  log_shifter #(.WIDTH(W)) i_log_shifter (
    .data_i(din), .amt_i(amt), .dir_i(dir), .mode_i(mode), .data_o(dout)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] d, int a, logic r, logic [1:0] m);
    logic [W-1:0] x = d;
    if (m == 2'b11) return d;
    for (int i = 0; i < a; i++) begin
      if (!r) x = (m == 2'b10) ? {x[W-2:0], x[W-1]} : {x[W-2:0], 1'b0};
      else if (m == 2'b10) x = {x[0], x[W-1:1]};
      else if (m == 2'b01) x = {x[W-1], x[W-1:1]};
      else x = {1'b0, x[W-1:1]};
    end
    return x;
  endfunction

  function automatic string tag(int a, logic r, logic [1:0] m);
    if (m == 2'b11) return "R8";
    if (a == 0) return "R7";
    case ({m, r})
      3'b000: return "R1 R9";
      3'b001: return "R2 R9";
      3'b011: return "R3 R9";
      3'b010: return "R6 R9";
      3'b100: return "R4 R9";
      default: return "R5 R9";
    endcase
  endfunction

  task automatic apply(logic [W-1:0] d, int a, logic r, logic [1:0] m,
                       logic [W-1:0] exp, string t);
    @(negedge clk);
    din = d; amt = C'(a); dir = r; mode = m;
    @(posedge clk); #1;
    n_vec++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: d=%b cnt=%0d dir=%0d mode=%0d got %b expected %b",
               t, d, a, r, m, dout, exp);
    end
  endtask

  initial begin
    din = '0; amt = '0; dir = 1'b0; mode = 2'b00;
    void'($urandom(32'h1d5e_ed01));
    apply(8'h00, 0, 0, 2'b00, 8'h00, "R7 idle");
    apply(8'b1001_0110, 1, 0, 2'b10, 8'b0010_1101, "R4 example");
    apply(8'b1001_0110, 1, 1, 2'b01, 8'b1100_1011, "R3 example");
    apply(8'b1001_0110, 2, 0, 2'b00, 8'b0101_1000, "R1 two");
    apply(8'b1001_0110, 2, 1, 2'b00, 8'b0010_0101, "R2 two");
    apply(8'b1001_0110, 1, 1, 2'b10, 8'b0100_1011, "R5 one");
    apply(8'b1001_0110, 3, 0, 2'b01, 8'b1011_0000, "R6 arith left");
    apply(8'b1111_1111, 7, 0, 2'b00, 8'b1000_0000, "R10 left max");
    apply(8'b1111_1111, 7, 1, 2'b00, 8'b0000_0001, "R10 right max");
    apply(8'b1000_0000, 7, 1, 2'b01, 8'b1111_1111, "R3 max");
    apply(8'b1010_0101, 5, 1, 2'b11, 8'b1010_0101, "R8 spare");
    apply(8'b0110_0011, 0, 1, 2'b10, 8'b0110_0011, "R7 zero");
    for (int a = 0; a < W; a++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 2; r++)
          apply(8'hB4, a, r[0], m[1:0], model(8'hB4, a, r[0], m[1:0]),
                tag(a, r[0], m[1:0]));
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d = W'($urandom);
      int a = int'($urandom % W);
      logic r = 1'($urandom);
      logic [1:0] m = 2'($urandom);
      apply(d, a, r, m, model(d, a, r, m), tag(a, r, m));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule